// File: doc/BRIEF.md
# Power-Up Configuration Table Loader

After each reset release, the loader fills a volatile configuration register file from one of four tables in a one-time-programmable (OTP) byte array. In its first active cycle it samples a mode strap, once. A low strap selects serial-host mode, which always uses table 0. A high strap selects pin-select mode, where a two-bit select input picks table 0, 1, 2 or 3. The choice then holds until the next reset, which stands for a power cycle.

The loader reads the OTP array through a synchronous port with one cycle of latency. It issues addresses in increasing order and writes each byte into the register file one cycle after issuing its address. The copied register window runs from 0x14 through 0x6D, which is 90 bytes. Register r of table t comes from OTP address t*0x5A + r. The OTP model follows the fuse rule: bits start at 1 and a burn can only clear them.

The state machine moves through these states. LATCH samples the strap and the select pins. COPY issues one OTP address per cycle and leaves after the 90th. DRAIN writes the last byte. PULSE raises done for one cycle. READY holds. There are four transitions: LATCH→COPY unconditionally, COPY→DRAIN on the last count, DRAIN→PULSE, and PULSE→READY. Reset returns the machine to LATCH.

Top module: `cfg_table_loader`

## Requirements
- R1: While reset is held, and from its release until the load completes, busy is 1 and done is 0. Volatile registers reset to 0x00.
- R2: The strap is sampled in the first clock after reset release, and pin_mode then shows it (1 = pin-select). Later changes on the strap or the select pins do not change pin_mode, table_idx or the loaded contents until the next reset.
- R3: In host mode (strap 0), table_idx is 0 and table 0 is loaded whatever the select pins show.
- R4: In pin-select mode, table_idx equals table_sel, with table_sel[1] as the MSB, and that table is loaded.
- R5: After the load, each register r in 0x14..0x6D holds the OTP byte at address table_idx*0x5A + r.
- R6: After the load, registers outside 0x14..0x6D keep their reset value 0x00.
- R7: done is high for exactly one cycle. It is first seen after the 92nd rising edge following reset release, in the same cycle that busy falls, and busy stays low afterwards.
- R8: Host writes are ignored while busy is 1. When busy is 0, a host write to an address below 0xA0 is readable in the next cycle. Writes at or above 0xA0 are ignored, and reads there return 0x00.
- R9: OTP bytes start at 0xFF. A burn ANDs its data into the byte, so no bit ever returns from 0 to 1, and unburned bytes load as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; models a power cycle |
| mode_strap | input | 1 | Mode strap: 1 = pin-select, 0 = host |
| table_sel | input | 2 | Table select pins |
| burn_en | input | 1 | OTP burn strobe |
| burn_addr | input | 9 | OTP burn address |
| burn_data | input | 8 | Burn data; 0 bits clear fuses |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_rd_addr | input | 8 | Host read address |
| host_rd_data | output | 8 | Combinational register read data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| pin_mode | output | 1 | Latched mode |
| table_idx | output | 2 | Table chosen for the load |

## Verification
Assertions check these on every cycle: done lasts one cycle and never overlaps busy; host mode reports table 0; mode and table stay stable once loading has finished; every loader write lands inside the window; OTP reads stay in range; no burn raises a bit; and a loader write never coincides with a host write. Only the bench scenarios show the rest: that each of the 90 bytes arrives from the correct table offset, that the load takes exactly 92 cycles, that strap and select changes during a load are ignored, that a host write made while busy is lost, and that a second burn only clears bits. The bench sweeps both modes and all four select codes.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
    typedef enum logic [2:0] {
        S_LATCH,
        S_COPY,
        S_DRAIN,
        S_PULSE,
        S_READY
    } ld_state_e;

    localparam int DEF_FIRST = 'h14;
    localparam int DEF_LAST  = 'h6D;
    localparam int DEF_RF_DEPTH = 160;
endpackage

// File: rtl/cfg_otp_array.sv
module cfg_otp_array #(
    parameter int DEPTH = 380,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          burn_en,
    input  logic [AW-1:0] burn_addr,
    input  logic [DW-1:0] burn_data
);
    logic [DW-1:0] mem [DEPTH];
    logic          burn_ok;
    logic [DW-1:0] old_byte;

    // unburned fuses read as all ones
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
        rd_data = '1;
    end

    assign burn_ok  = burn_en && (int'(burn_addr) < DEPTH);
    assign old_byte = (int'(burn_addr) < DEPTH) ? mem[burn_addr] : '1;

    always @(posedge clk) begin
        if (burn_ok) mem[burn_addr] <= mem[burn_addr] & burn_data;
    end

    always @(posedge clk) begin
        if (rd_en) rd_data <= (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '1;
    end

    // R9
    burn_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burn_ok |=> ((mem[$past(burn_addr)] & ~$past(old_byte)) == '0));

    // R5
    rd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < DEPTH));
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
    parameter int DEPTH = 160,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] regs [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (ld_we) begin
            if (int'(ld_addr) < DEPTH) regs[ld_addr] <= ld_data;
        end else if (host_we) begin
            if (int'(host_addr) < DEPTH) regs[host_addr] <= host_wdata;
        end
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? regs[rd_addr] : '0;

    // R8
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> !host_we);
endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
    import cfg_ld_pkg::*;
#(
    parameter int FIRST = DEF_FIRST,
    parameter int LAST  = DEF_LAST,
    parameter int TBL_W = 2,
    parameter int NV_AW = 9,
    parameter int RF_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap,
    input  logic [TBL_W-1:0] sel,
    output logic             rd_en,
    output logic [NV_AW-1:0] rd_addr,
    output logic             ld_we,
    output logic [RF_AW-1:0] ld_addr,
    output logic             busy,
    output logic             done,
    output logic             pin_mode,
    output logic [TBL_W-1:0] table_idx
);
    localparam int SPAN = LAST - FIRST + 1;
    localparam int CW   = $clog2(SPAN + 1);

    ld_state_e        state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic             pend_q;
    logic [RF_AW-1:0] pend_addr_q;
    logic             mode_q;
    logic [TBL_W-1:0] table_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_LATCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_LATCH: state_d = S_COPY;
            S_COPY:  if (cnt_q == CW'(SPAN - 1)) state_d = S_DRAIN;
            S_DRAIN: state_d = S_PULSE;
            S_PULSE: state_d = S_READY;
            S_READY: state_d = S_READY;
            default: state_d = S_LATCH;
        endcase
    end

    always_comb begin
        rd_en = 1'b0;
        busy  = 1'b1;
        done  = 1'b0;
        unique case (state_q)
            S_LATCH: ;
            S_COPY:  rd_en = 1'b1;
            S_DRAIN: ;
            S_PULSE: begin busy = 1'b0; done = 1'b1; end
            S_READY: busy = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            mode_q      <= 1'b0;
            table_q     <= '0;
        end else begin
            pend_q      <= (state_q == S_COPY);
            pend_addr_q <= RF_AW'(FIRST + int'(cnt_q));
            if (state_q == S_LATCH) begin
                mode_q  <= strap;
                table_q <= strap ? sel : '0;
            end
            if (state_q == S_COPY) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign rd_addr   = NV_AW'(int'(table_q) * SPAN + FIRST + int'(cnt_q));
    assign ld_we     = pend_q;
    assign ld_addr   = pend_addr_q;
    assign pin_mode  = mode_q;
    assign table_idx = table_q;

    // R5
    ld_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> (int'(ld_addr) >= FIRST && int'(ld_addr) <= LAST));

    // R7
    ld_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> busy);
endmodule

// File: rtl/cfg_table_loader.sv
module cfg_table_loader
    import cfg_ld_pkg::*;
#(
    parameter int FIRST    = DEF_FIRST,
    parameter int LAST     = DEF_LAST,
    parameter int RF_DEPTH = DEF_RF_DEPTH,
    parameter int TBL_W    = 2,
    parameter int NV_AW    = 9,
    parameter int RF_AW    = 8,
    parameter int DW       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_strap,
    input  logic [TBL_W-1:0] table_sel,
    input  logic             burn_en,
    input  logic [NV_AW-1:0] burn_addr,
    input  logic [DW-1:0]    burn_data,
    input  logic             host_wr_en,
    input  logic [RF_AW-1:0] host_addr,
    input  logic [DW-1:0]    host_wdata,
    input  logic [RF_AW-1:0] host_rd_addr,
    output logic [DW-1:0]    host_rd_data,
    output logic             busy,
    output logic             done,
    output logic             pin_mode,
    output logic [TBL_W-1:0] table_idx
);
    localparam int SPAN       = LAST - FIRST + 1;
    localparam int NUM_TABLES = 1 << TBL_W;
    localparam int NV_DEPTH   = NUM_TABLES * SPAN + FIRST;

    logic             rd_en;
    logic [NV_AW-1:0] rd_addr;
    logic [DW-1:0]    rd_data;
    logic             ld_we;
    logic [RF_AW-1:0] ld_addr;
    logic             host_we;

    cfg_load_fsm #(
        .FIRST(FIRST), .LAST(LAST), .TBL_W(TBL_W), .NV_AW(NV_AW), .RF_AW(RF_AW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .strap(mode_strap), .sel(table_sel),
        .rd_en(rd_en), .rd_addr(rd_addr), .ld_we(ld_we), .ld_addr(ld_addr),
        .busy(busy), .done(done), .pin_mode(pin_mode), .table_idx(table_idx)
    );

    cfg_otp_array #(.DEPTH(NV_DEPTH), .AW(NV_AW), .DW(DW)) u_otp (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .burn_en(burn_en), .burn_addr(burn_addr),
        .burn_data(burn_data)
    );

    assign host_we = host_wr_en && !busy;

    cfg_reg_file #(.DEPTH(RF_DEPTH), .AW(RF_AW), .DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(rd_data), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .rd_addr(host_rd_addr), .rd_data(host_rd_data)
    );

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    busy_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);

    // R3
    host_table0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_mode |-> (table_idx == '0));

    // R2
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(pin_mode) && $stable(table_idx)));
endmodule

// File: tb/cfg_table_loader_bench.sv
module cfg_table_loader_bench;
    localparam int FIRST = 'h14;
    localparam int LAST  = 'h6D;
    localparam int SPAN  = LAST - FIRST + 1;
    localparam int NVD   = 4 * SPAN + FIRST;
    localparam int RFD   = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_strap = 1'b0;
    logic [1:0] table_sel = 2'd0;
    logic       burn_en = 1'b0;
    logic [8:0] burn_addr = '0;
    logic [7:0] burn_data = '0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rd_addr = '0;
    logic [7:0] host_rd_data;
    logic       busy, done, pin_mode;
    logic [1:0] table_idx;

    int checks = 0;
    int fails  = 0;
    logic [7:0] nvexp [NVD];

    always #4 clk = ~clk;

    cfg_table_loader u_cfg_table_loader (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .table_sel(table_sel),
        .burn_en(burn_en), .burn_addr(burn_addr), .burn_data(burn_data),
        .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .busy(busy), .done(done), .pin_mode(pin_mode), .table_idx(table_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic burn(input int a, input logic [7:0] d);
        @(negedge clk);
        burn_en = 1'b1; burn_addr = 9'(a); burn_data = d;
        @(negedge clk);
        burn_en = 1'b0;
        nvexp[a] = nvexp[a] & d;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        host_rd_addr = 8'(a);
        #1;
        d = host_rd_data;
    endtask

    task automatic run_load(input logic strap_v, input logic [1:0] sel_v);
        int k;
        int exp_t;
        bit busy_bad;
        logic [7:0] d;
        logic [7:0] e;
        @(negedge clk);
        rst_n = 1'b0; mode_strap = strap_v; table_sel = sel_v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b1 && done == 1'b0, "R1", {busy, done}, 2'b10);
        rd('h30, d);
        chk(d == 8'h00, "R1", d, 0);
        rst_n = 1'b1;
        k = 0;
        busy_bad = 0;
        while (k < 300) begin
            @(negedge clk);
            k++;
            if (k == 5) begin mode_strap = ~strap_v; table_sel = ~sel_v; end
            if (k == 10) begin host_wr_en = 1'b1; host_addr = 8'h05; host_wdata = 8'h77; end
            if (k == 11) host_wr_en = 1'b0;
            if (done) break;
            if (busy !== 1'b1) busy_bad = 1;
        end
        // R1 busy held until completion
        chk(!busy_bad, "R1", busy_bad, 0);
        // R7 latency and pulse
        chk(k == SPAN + 2, "R7", k, SPAN + 2);
        chk(busy == 1'b0, "R7", busy, 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7", {busy, done}, 0);
        // R2 mode latched despite strap change
        chk(pin_mode == strap_v, "R2", pin_mode, strap_v);
        exp_t = strap_v ? int'(sel_v) : 0;
        if (strap_v) chk(int'(table_idx) == exp_t, "R4", table_idx, exp_t);
        else         chk(int'(table_idx) == 0, "R3", table_idx, 0);
        for (int r = 0; r < RFD; r++) begin
            rd(r, d);
            if (r >= FIRST && r <= LAST) begin
                e = nvexp[exp_t * SPAN + r];
                chk(d == e, strap_v ? "R5_R4" : "R5_R3", d, e);
            end else begin
                // R6, and R8 for the host write made while busy at 0x05
                chk(d == 8'h00, (r == 5) ? "R8" : "R6", d, 0);
            end
        end
        mode_strap = strap_v; table_sel = sel_v;
    endtask

    initial begin
        logic [7:0] d;
        for (int a = 0; a < NVD; a++) nvexp[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < NVD; a++)
            if (a % 37 != 0) burn(a, 8'((a * 13) ^ (a >> 2) ^ 'h3C));

        for (int s = 0; s < 2; s++)
            for (int t = 0; t < 4; t++)
                run_load(s[0], 2'(t));

        // R9 second burns only clear bits; all-ones burn changes nothing
        for (int a = 20; a < 30; a++) burn(a, 8'h0F);
        burn(30, 8'hFF);
        burn(FIRST + SPAN + 3, 8'hF0);
        run_load(1'b0, 2'd3);
        rd(20, d);
        chk(d == nvexp[20], "R9", d, nvexp[20]);
        chk((d & 8'hF0) == 8'h00, "R9", d & 8'hF0, 0);
        run_load(1'b1, 2'd1);
        rd(FIRST + 3, d);
        chk(d == nvexp[SPAN + FIRST + 3], "R9", d, nvexp[SPAN + FIRST + 3]);
        // R9 unburned byte 0x25 (multiple of 37) of table 0 loads 0xFF
        run_load(1'b0, 2'd0);
        rd(37, d);
        chk(d == 8'hFF, "R9", d, 8'hFF);

        // R8 host writes after load
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = 8'h20; host_wdata = 8'hC3;
        @(negedge clk);
        host_addr = 8'hB0; host_wdata = 8'hA5;
        @(negedge clk);
        host_addr = 8'h9F; host_wdata = 8'h5A;
        @(negedge clk);
        host_wr_en = 1'b0;
        rd('h20, d); chk(d == 8'hC3, "R8", d, 8'hC3);
        rd('h9F, d); chk(d == 8'h5A, "R8", d, 8'h5A);
        rd('hB0, d); chk(d == 8'h00, "R8", d, 0);
        rd('hFF, d); chk(d == 8'h00, "R8", d, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(64'd8 * 64'd200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule